// File: doc/BRIEF.md
# Paged Read Sequencer with Redirection

This block answers the two read commands of a small one-time-programmable memory of four pages, each 32 bytes long, over a byte-oriented serial slave link. The link delivers whole bytes from the master (`rx_valid`/`rx_byte`). Each master read slot arrives as a byte request (`rd_req`), and a bus reset pulse (`bus_reset`) abandons the current transaction. Bit timing is handled elsewhere. Every transaction starts with a command byte and a start address sent low byte first. The block then drives the data-array address and the status-memory address, and it runs its own 16-bit CRC generator.

In plain mode (command F0h) the block streams bytes from the start address up to the last byte of memory. It then appends a CRC over everything exchanged. In extended mode (command A5h) each page is wrapped in a frame: first its redirection byte, then a CRC, then the page data from the current position to the page end, then a CRC over that data. The first frame's header CRC also covers the command and the address. The header CRC of each later frame covers only its own redirection byte. When a stream is complete, the block returns all-ones bytes until the next bus reset.

Top module: `pgrd_seq`

## Requirements
- R1: After reset `rd_valid` is 0 and `rd_data` is FFh.
- R2: After command F0h and its two address bytes, successive reads return data-array bytes in rising address order, from the start address through address 127.
- R3: In plain mode, the two reads after address 127 return a CRC16 over the command, both address bytes as received and every data byte sent. The CRC uses polynomial x^16+x^15+x^2+1, is shifted least significant bit first, starts from zero, and is sent bitwise inverted, low byte first.
- R4: Once the final CRC of either mode has been sent, every further read returns FFh.
- R5: A `bus_reset` pulse abandons the transaction at any point, so no CRC is produced for it. Reads then return FFh until a new command and address are received, after which a fresh transaction runs normally.
- R6: Indexing uses only bits 6:0 of the low address byte. The high address byte and bit 7 of the low byte are ignored for indexing but still enter the CRC.
- R7: After command A5h and its address, the first read returns the status byte at address 1 + page of the start address, with page = address bits 6:5. The next two reads return the inverted CRC over the command, both address bytes and that redirection byte.
- R8: In extended mode, data runs from the current address to the last byte of its page. It is followed by the inverted CRC over those data bytes alone, computed from a cleared generator.
- R9: In extended mode, each later page is framed by its redirection byte and the inverted CRC of that byte alone, then its data from byte 0. The frame of page 3 is the last one.
- R10: A command byte other than F0h or A5h makes every later read return FFh, and it makes every later received byte have no effect until `bus_reset`.
- R11: A read issued before the address is complete returns FFh and does not change the stream that follows.
- R12: `rd_valid` is high exactly in the cycle after each `rd_req`, with `rd_data` holding the answer in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Link reset pulse; aborts the transaction |
| rx_valid | input | 1 | A byte from the master is present |
| rx_byte | input | 8 | Byte from the master |
| rd_req | input | 1 | Master read slot for one byte |
| rd_data | output | 8 | Byte answered to the last read request |
| rd_valid | output | 1 | `rd_data` is fresh this cycle |
| mem_addr | output | 7 | Data-array byte address |
| mem_rdata | input | 8 | Data-array byte at `mem_addr` (same-cycle read) |
| stat_addr | output | 3 | Status-memory address of the current page's redirection byte |
| stat_rdata | input | 8 | Status byte at `stat_addr` (same-cycle read) |

## Verification
A wrong position counter shows up on the very next answered byte as data from the wrong address. A wrongly seeded CRC register stays hidden until the two CRC bytes at the end of a page or stream, so each mode is run from start addresses that put those boundaries at different distances. A stuck frame state shows as a missing redirection byte, a missing CRC, or all-ones data one read later. Aborts, unknown commands and early reads are driven and then probed at the port, because their effect would otherwise appear only in the next transaction's first byte.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ALO,
      ST_AHI,
      ST_DATA,
      ST_RED,
      ST_CLO,
      ST_CHI,
      ST_DONE
   } pgrd_state_e;

   localparam logic [7:0] OP_PLAIN = 8'hF0;
   localparam logic [7:0] OP_EXT   = 8'hA5;

   // one byte through a reflected CRC16, least significant bit first
   function automatic logic [15:0] crc16_byte(input logic [15:0] seed,
                                               input logic [7:0]  din,
                                               input logic [15:0] poly_r);
      logic [15:0] c;
      c = seed;
      for (int i = 0; i < 8; i++) begin
         if (c[0] ^ din[i]) c = (c >> 1) ^ poly_r;
         else               c = c >> 1;
      end
      return c;
   endfunction

endpackage

// File: rtl/pgrd_crc16.sv
module pgrd_crc16 #(
   parameter logic [15:0] POLY_R = 16'hA001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   import pgrd_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= '0;
      else if (clr) crc <= '0;
      else if (en)  crc <= crc16_byte(crc, din, POLY_R);
   end

endmodule

// File: rtl/pgrd_cursor.sv
module pgrd_cursor #(
   parameter int ADDR_W = 7,
   parameter int PAGE_W = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [ADDR_W-1:0]          load_val,
   input  logic                       step,
   output logic [ADDR_W-1:0]          addr,
   output logic [ADDR_W-PAGE_W-1:0]   page,
   output logic                       pg_end,
   output logic                       mem_end
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr <= '0;
      else if (load)  addr <= load_val;
      else if (step)  addr <= addr + 1'b1;
   end

   assign page    = addr[ADDR_W-1:PAGE_W];
   assign pg_end  = &addr[PAGE_W-1:0];
   assign mem_end = &addr;

endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_reset,
   input  logic                  rx_valid,
   input  logic [7:0]            rx_byte,
   input  logic                  rd_req,
   input  logic [7:0]            mem_rdata,
   input  logic [7:0]            stat_rdata,
   input  logic [15:0]           crc_tx,
   input  logic                  pg_end,
   input  logic                  mem_end,
   output logic                  cur_load,
   output logic                  cur_step,
   output logic                  crc_clr,
   output logic                  crc_en,
   output logic [7:0]            crc_din,
   output logic [7:0]            rd_data,
   output logic                  rd_valid,
   output pgrd_pkg::pgrd_state_e st,
   output logic                  ext
);
   import pgrd_pkg::*;

   pgrd_state_e st_n;
   logic        ext_n, hdr_q, hdr_n, fin_q, fin_n;
   logic [7:0]  tx;

   always_comb begin
      st_n     = st;
      ext_n    = ext;
      hdr_n    = hdr_q;
      fin_n    = fin_q;
      tx       = 8'hFF;
      crc_clr  = 1'b0;
      crc_en   = 1'b0;
      crc_din  = rx_byte;
      cur_load = 1'b0;
      cur_step = 1'b0;
      if (bus_reset) begin
         st_n    = ST_CMD;
         crc_clr = 1'b1;
      end else begin
         unique case (st)
            ST_CMD: if (rx_valid) begin
               if (rx_byte == OP_PLAIN || rx_byte == OP_EXT) begin
                  crc_en = 1'b1;
                  ext_n  = (rx_byte == OP_EXT);
                  st_n   = ST_ALO;
               end else begin
                  st_n = ST_DONE;
               end
            end
            ST_ALO: if (rx_valid) begin
               crc_en   = 1'b1;
               cur_load = 1'b1;
               st_n     = ST_AHI;
            end
            ST_AHI: if (rx_valid) begin
               crc_en = 1'b1;
               st_n   = ext ? ST_RED : ST_DATA;
            end
            ST_DATA: if (rd_req) begin
               tx       = mem_rdata;
               crc_en   = 1'b1;
               crc_din  = mem_rdata;
               cur_step = 1'b1;
               if (ext ? pg_end : mem_end) begin
                  st_n  = ST_CLO;
                  hdr_n = 1'b0;
                  fin_n = mem_end;
               end
            end
            ST_RED: if (rd_req) begin
               tx      = stat_rdata;
               crc_en  = 1'b1;
               crc_din = stat_rdata;
               hdr_n   = 1'b1;
               st_n    = ST_CLO;
            end
            ST_CLO: if (rd_req) begin
               tx   = crc_tx[7:0];
               st_n = ST_CHI;
            end
            ST_CHI: if (rd_req) begin
               tx = crc_tx[15:8];
               if (!ext || (!hdr_q && fin_q)) begin
                  st_n = ST_DONE;
               end else begin
                  crc_clr = 1'b1;
                  st_n    = hdr_q ? ST_DATA : ST_RED;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_CMD;
         ext      <= 1'b0;
         hdr_q    <= 1'b0;
         fin_q    <= 1'b0;
         rd_data  <= 8'hFF;
         rd_valid <= 1'b0;
      end else begin
         st       <= st_n;
         ext      <= ext_n;
         hdr_q    <= hdr_n;
         fin_q    <= fin_n;
         rd_valid <= rd_req;
         if (rd_req) rd_data <= tx;
      end
   end

endmodule

// File: rtl/pgrd_seq.sv
module pgrd_seq #(
   parameter int          ADDR_W  = 7,
   parameter int          PAGE_W  = 5,
   parameter logic [15:0] POLY_R  = 16'hA001,
   parameter bit          CRC_INV = 1'b1,
   localparam int         PG_W    = ADDR_W - PAGE_W,
   localparam int         SA_W    = PG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rd_req,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic [SA_W-1:0]   stat_addr,
   input  logic [7:0]        stat_rdata
);
   import pgrd_pkg::*;

   initial begin
      assert (ADDR_W <= 8 && ADDR_W > PAGE_W && PAGE_W > 0)
         else $error("pgrd_seq: address fields do not fit one byte");
   end

   logic              cur_load, cur_step, pg_end, mem_end;
   logic [PG_W-1:0]   page;
   logic              crc_clr, crc_en;
   logic [7:0]        crc_din;
   logic [15:0]       crc_q, crc_tx;
   pgrd_state_e       st;
   logic              ext;

   pgrd_cursor #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cursor (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cur_load),
      .load_val (rx_byte[ADDR_W-1:0]),
      .step     (cur_step),
      .addr     (mem_addr),
      .page     (page),
      .pg_end   (pg_end),
      .mem_end  (mem_end)
   );

   pgrd_crc16 #(.POLY_R(POLY_R)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .en    (crc_en),
      .din   (crc_din),
      .crc   (crc_q)
   );

   generate
      if (CRC_INV) begin : g_crc_inv
         assign crc_tx = ~crc_q;
      end else begin : g_crc_raw
         assign crc_tx = crc_q;
      end
   endgenerate

   assign stat_addr = {1'b0, page} + 1'b1;

   pgrd_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_reset  (bus_reset),
      .rx_valid   (rx_valid),
      .rx_byte    (rx_byte),
      .rd_req     (rd_req),
      .mem_rdata  (mem_rdata),
      .stat_rdata (stat_rdata),
      .crc_tx     (crc_tx),
      .pg_end     (pg_end),
      .mem_end    (mem_end),
      .cur_load   (cur_load),
      .cur_step   (cur_step),
      .crc_clr    (crc_clr),
      .crc_en     (crc_en),
      .crc_din    (crc_din),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid),
      .st         (st),
      .ext        (ext)
   );

endmodule

// File: rtl/pgrd_seq_chk.sv
module pgrd_seq_chk #(
   parameter int ADDR_W = 7,
   parameter int PAGE_W = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_reset,
   input logic                  rd_req,
   input logic                  rd_valid,
   input logic [7:0]            rd_data,
   input logic [ADDR_W-1:0]     mem_addr,
   input pgrd_pkg::pgrd_state_e st,
   input logic                  ext
);
   import pgrd_pkg::*;

   assert_valid_after_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   assert_valid_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

   assert_abort_to_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> st == ST_CMD);

   assert_ones_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE && rd_req && !bus_reset) |=> rd_data == 8'hFF);

   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && rd_req && !bus_reset) |=>
         (st != ST_DATA || mem_addr == $past(mem_addr) + 1'b1));

   assert_plain_crc_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && rd_req && !bus_reset && !ext && &mem_addr) |=> st == ST_CLO);

   assert_page_crc_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && rd_req && !bus_reset && ext && &mem_addr[PAGE_W-1:0]) |=> st == ST_CLO);

endmodule

bind pgrd_seq pgrd_seq_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_reset (bus_reset),
   .rd_req    (rd_req),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .mem_addr  (mem_addr),
   .st        (st),
   .ext       (ext)
);

// File: tb/tb_pgrd_seq.sv
module tb_pgrd_seq;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_reset = 1'b0, rx_valid = 1'b0, rd_req = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic [7:0] rd_data, mem_rdata, stat_rdata;
   logic       rd_valid;
   logic [6:0] mem_addr;
   logic [2:0] stat_addr;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgrd_seq dut (.*);

   function automatic logic [7:0] mem_f(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction
   function automatic logic [7:0] stat_f(input int s);
      return 8'hFF ^ 8'((s * 17) & 255);
   endfunction
   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c;
      for (int k = 0; k < 8; k++) begin
         logic fb = r[0] ^ b[k];
         r = {1'b0, r[15:1]};
         if (fb) r = r ^ 16'hA001;
      end
      return r;
   endfunction

   assign mem_rdata  = mem_f(int'(mem_addr));
   assign stat_rdata = stat_f(int'(stat_addr));

   // cmd, addr lo, addr hi, expected first byte
   localparam logic [31:0] VEC [7] = '{
      32'hF0_00_00_0B, 32'hF0_7C_00_F7, 32'hF0_F9_3A_88, 32'hF0_FF_01_66,
      32'hA5_3E_00_DD, 32'hA5_65_FF_BB, 32'hA5_00_00_EE };

   logic [7:0] ev [0:299];
   string      et [0:299];
   int         n_ev;

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic rd(output logic [7:0] v);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0; v = rd_data;
   endtask

   task automatic abort();
      @(negedge clk); bus_reset = 1'b1;
      @(negedge clk); bus_reset = 1'b0;
   endtask

   task automatic push(input logic [7:0] b, input string t);
      ev[n_ev] = b; et[n_ev] = t; n_ev++;
   endtask

   task automatic build(input logic [7:0] cmd, input logic [7:0] lo, input logic [7:0] hi);
      logic [15:0] c;
      int a;
      string dt;
      n_ev = 0;
      a = int'(lo & 8'h7F);
      dt = (lo[7] || hi != 0) ? "R6" : "R2";
      c = crc_step(crc_step(crc_step(16'h0, cmd), lo), hi);
      if (cmd == 8'hF0) begin
         for (int i = a; i < 128; i++) begin
            push(mem_f(i), dt); c = crc_step(c, mem_f(i));
         end
         push(~c[7:0], "R3"); push(~c[15:8], "R3");
      end else begin
         for (int p = a / 32; p < 4; p++) begin
            logic [7:0] r = stat_f(p + 1);
            if (p != a / 32) c = 16'h0;
            push(r, (p == a / 32) ? "R7" : "R9");
            c = crc_step(c, r);
            push(~c[7:0], (p == a / 32) ? "R7" : "R9");
            push(~c[15:8], (p == a / 32) ? "R7" : "R9");
            c = 16'h0;
            for (int i = ((p == a / 32) ? a : p * 32); i < p * 32 + 32; i++) begin
               push(mem_f(i), "R8"); c = crc_step(c, mem_f(i));
            end
            push(~c[7:0], "R8"); push(~c[15:8], "R8");
         end
      end
   endtask

   task automatic summary();
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R12 watchdog: actual hung expected done");
         summary();
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_data, 8'hFF, "R1 rd_data");
      chk({7'b0, rd_valid}, 8'h01 & 8'h00, "R1 rd_valid");
      rst_n = 1'b1;
      @(negedge clk);
      chk({7'b0, rd_valid}, 8'h00, "R1 rd_valid after release");

      // vector table
      for (int t = 0; t < 7; t++) begin
         abort();
         send(VEC[t][31:24]); send(VEC[t][23:16]); send(VEC[t][15:8]);
         build(VEC[t][31:24], VEC[t][23:16], VEC[t][15:8]);
         for (int i = 0; i < n_ev; i++) begin
            rd(v);
            if (i == 0) chk(v, VEC[t][7:0], (VEC[t][31:24] == 8'hF0) ? "R2 first" : "R7 first");
            chk(v, ev[i], et[i]);
         end
         for (int k = 0; k < 3; k++) begin
            rd(v); chk(v, 8'hFF, "R4 tail");
         end
      end

      // R12 strobe timing
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      chk({7'b0, rd_valid}, 8'h01, "R12 valid high");
      @(negedge clk);
      chk({7'b0, rd_valid}, 8'h00, "R12 valid low");

      // R5 abort mid-stream
      abort();
      send(8'hF0); send(8'h10); send(8'h00);
      for (int k = 0; k < 4; k++) begin
         rd(v); chk(v, mem_f(16 + k), "R5 pre-abort data");
      end
      abort();
      for (int k = 0; k < 3; k++) begin
         rd(v); chk(v, 8'hFF, "R5 no CRC after abort");
      end
      send(8'hF0); send(8'h10); send(8'h00);
      rd(v); chk(v, mem_f(16), "R5 restart");

      // R10 unknown command
      abort();
      send(8'h3C); send(8'h00); send(8'h00);
      rd(v); chk(v, 8'hFF, "R10 unknown read");
      send(8'hF0); send(8'h00); send(8'h00);
      rd(v); chk(v, 8'hFF, "R10 bytes ignored");

      // R11 early read
      abort();
      send(8'hA5);
      rd(v); chk(v, 8'hFF, "R11 early read");
      send(8'h40); send(8'h00);
      rd(v); chk(v, stat_f(3), "R11 stream intact");

      summary();
   end

endmodule